// File: doc/BRIEF.md
# Dual-Half LCD Refresh Scan Generator

This block drives a dot-matrix LCD in graphic mode whose panel is split into an upper and a lower half that are scanned at the same moment. From a small set of programmed values (dots per byte, bytes per line, lines per half and the RAM address of the top-left byte) it walks two refresh address counters through an external synchronous RAM. It fetches one byte for each half in every byte period and shifts the displayed bits of both bytes out on two serial lines side by side.

Each byte period is as many clocks as there are dots per byte. Its memory time is split into three slots in a fixed order: upper-half fetch, lower-half fetch, then a slot that a host may use to read or write the RAM. Alongside the dot streams the block produces a dot-valid qualifier, a one-cycle line latch pulse, a frame marker for the first scan line and an AC-conversion level that flips once per frame. The mode and geometry inputs are expected to change only while reset is held.

Top module: `lcd_dual_scan`

## Requirements
- R1: While reset is held and in the cycle right after it, the dot outputs, dot_valid, line_latch, frame_mark, ac_flip, mem_re, mem_we and cpu_grant are all low.
- R2: The byte period lasts Hp clocks, where Hp = pitch_m1 + 1 for pitch_m1 of 5, 6 or 7; any pitch_m1 below 5 gives Hp = 6. Counting clocks from the first cycle after reset as c = 0, period k covers c = k*Hp to k*Hp+Hp-1 and the phase is c mod Hp.
- R3: With HN = hn_m1+1, NX = nx_m1+1, F = HN*NX and m = k mod F, the upper-half fetch shows mem_re high with mem_addr = start_addr + m in phase 1 of period k. The lower-half fetch shows mem_re high with mem_addr = start_addr + F + m in phase Hp-3. Both counters return to their start values after the last byte of a frame.
- R4: During period k+1, in phase p, up_dot and lo_dot carry bit p (bit 0 first) of the upper and lower bytes fetched in period k. Bits at positions Hp and above are never shown. dot_valid is high from period 1 onward.
- R5: line_latch is high for exactly one cycle, in phase 0 of period k+2, when the byte fetched in period k was the last byte of a line (m mod HN = HN-1).
- R6: frame_mark is high throughout every period whose displayed byte belongs to the first line of a half (m < HN).
- R7: ac_flip starts at 0 and inverts in the same cycle as the line_latch pulse that closes the last line of a frame (m = F-1).
- R8: A pending cpu_req is served in the third slot: cpu_grant is high in phase Hp-1 together with mem_addr = cpu_addr, mem_we = cpu_we, mem_re = !cpu_we and mem_wdata = cpu_wdata; read data appears on mem_rdata in the following cycle. Without a request, mem_re and mem_we stay low in that slot and in every phase other than the two fetch phases.
- R9: With disp_on low, up_dot and lo_dot stay low while dot_valid, line_latch, frame_mark, ac_flip and the memory fetches follow R2 to R7 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pitch_m1 | input | 3 | Dots per byte minus one (5 to 7) |
| hn_m1 | input | HN_W | Bytes per line minus one |
| nx_m1 | input | NX_W | Lines per half minus one |
| start_addr | input | ADDR_W | RAM address of the top-left byte |
| disp_on | input | 1 | Enables the dot outputs |
| cpu_req | input | 1 | Host access pending |
| cpu_we | input | 1 | Host access is a write |
| cpu_addr | input | ADDR_W | Host access address |
| cpu_wdata | input | 8 | Host write data |
| cpu_grant | output | 1 | Host access is on the RAM bus this cycle |
| mem_addr | output | ADDR_W | RAM address |
| mem_re | output | 1 | RAM read enable |
| mem_we | output | 1 | RAM write enable |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, one cycle after mem_re |
| up_dot | output | 1 | Serial dots for the upper half |
| lo_dot | output | 1 | Serial dots for the lower half |
| dot_valid | output | 1 | Dot outputs carry a displayed dot |
| line_latch | output | 1 | One-cycle pulse after the last byte of a line |
| frame_mark | output | 1 | High while the first line is shown |
| ac_flip | output | 1 | AC-conversion level, flips once per frame |

## Verification
The bench sweeps whole frames for every pitch, including a clamped pitch code, with line lengths and half heights that are small enough to reach every wrap point several times. It goes after the slot placement per pitch, where a design that sized the upper slot wrongly would present the lower address in the wrong phase or let it collide with the capture of the upper byte. It watches the frame wrap of both counters, where a wrong reload would show bytes from past the end of the half or shift the lower half by a line. It also checks the dot order inside a byte: reversing it or showing bits above the pitch would corrupt every dot. The host slot is checked for a write followed by a read of the same location, and a run with the display off shows dark dots while the timing keeps running.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int BYTE_W = 8;

  // effective (pitch - 1); codes below 5 fall back to a pitch of 6
  function automatic logic [2:0] eff_pitch_m1(input logic [2:0] code);
    return (code < 3'd5) ? 3'd5 : code;
  endfunction
endpackage

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing
  import lcd_scan_pkg::*;
#(
  parameter int HN_W = 7,
  parameter int NX_W = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      pitch_m1,
  input  logic [HN_W-1:0] hn_m1,
  input  logic [NX_W-1:0] nx_m1,
  input  logic            disp_on,
  output logic            period_end,
  output logic            issue_up,
  output logic            issue_lo,
  output logic            issue_cpu,
  output logic            cap_up,
  output logic            cap_lo,
  output logic            last_byte,
  output logic            show_on,
  output logic            line_latch,
  output logic            frame_mark,
  output logic            ac_flip,
  output logic            dot_valid
);
  logic [2:0]      ph;
  logic [2:0]      hpm1;
  logic [HN_W-1:0] col, shown_col;
  logic [NX_W-1:0] row, shown_row;
  logic            shown_valid;
  logic            on_q;
  logic            lat_q, ac_q;
  logic            line_done, frame_done;

  assign hpm1       = eff_pitch_m1(pitch_m1);
  assign period_end = (ph == hpm1);
  assign issue_up   = (ph == 3'd0);
  assign issue_lo   = (ph == hpm1 - 3'd3);
  assign issue_cpu  = (ph == hpm1 - 3'd1);
  assign cap_up     = (ph == 3'd2);
  assign cap_lo     = (ph == hpm1 - 3'd1);
  assign last_byte  = (col == hn_m1) && (row == nx_m1);

  // position counters for the byte being fetched
  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= '0;
      col <= '0;
      row <= '0;
    end else if (period_end) begin
      ph <= '0;
      if (col == hn_m1) begin
        col <= '0;
        row <= (row == nx_m1) ? '0 : row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end else begin
      ph <= ph + 3'd1;
    end
  end

  // position of the byte currently on the dot outputs (one period behind)
  assign line_done  = period_end && shown_valid && (shown_col == hn_m1);
  assign frame_done = line_done && (shown_row == nx_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      shown_col   <= '0;
      shown_row   <= '0;
      shown_valid <= 1'b0;
      on_q        <= 1'b0;
      lat_q       <= 1'b0;
      ac_q        <= 1'b0;
    end else begin
      on_q  <= disp_on;
      lat_q <= line_done;
      if (frame_done) ac_q <= ~ac_q;
      if (period_end) begin
        shown_col   <= col;
        shown_row   <= row;
        shown_valid <= 1'b1;
      end
    end
  end

  assign show_on    = on_q && shown_valid;
  assign dot_valid  = shown_valid;
  assign line_latch = lat_q;
  assign frame_mark = shown_valid && (shown_row == '0);
  assign ac_flip    = ac_q;

  // R2
  ph_range_chk: assert property (@(posedge clk) disable iff (rst)
    ph <= eff_pitch_m1(pitch_m1));

  // R5
  latch_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    line_latch |=> !line_latch);

  // R7
  ac_with_latch_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ac_flip) |-> line_latch);
endmodule

// File: rtl/lcd_scan_fetch.sv
module lcd_scan_fetch
  import lcd_scan_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int HN_W   = 7,
  parameter int NX_W   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HN_W-1:0]   hn_m1,
  input  logic [NX_W-1:0]   nx_m1,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              issue_up,
  input  logic              issue_lo,
  input  logic              issue_cpu,
  input  logic              cap_up,
  input  logic              cap_lo,
  input  logic              last_byte,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BYTE_W-1:0] cpu_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              cpu_grant,
  output logic [BYTE_W-1:0] up_byte,
  output logic [BYTE_W-1:0] lo_byte
);
  localparam int AREA_W = HN_W + NX_W + 1;

  logic [AREA_W-1:0] hn_n, nx_n, area;
  logic [ADDR_W-1:0] area_a, lo_start;
  logic [ADDR_W-1:0] ua, la;

  assign hn_n     = AREA_W'(hn_m1) + 1'b1;
  assign nx_n     = AREA_W'(nx_m1) + 1'b1;
  assign area     = hn_n * nx_n;
  assign area_a   = ADDR_W'(area);
  assign lo_start = start_addr + area_a;

  // refresh address counters, one per half
  always_ff @(posedge clk) begin
    if (rst) begin
      ua <= start_addr;
      la <= lo_start;
    end else begin
      if (issue_up) ua <= last_byte ? start_addr : ua + 1'b1;
      if (issue_lo) la <= last_byte ? lo_start : la + 1'b1;
    end
  end

  // registered RAM port: three slots per byte period
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_re    <= 1'b0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      cpu_grant <= 1'b0;
    end else begin
      mem_re    <= 1'b0;
      mem_we    <= 1'b0;
      cpu_grant <= 1'b0;
      if (issue_up) begin
        mem_addr <= ua;
        mem_re   <= 1'b1;
      end else if (issue_lo) begin
        mem_addr <= la;
        mem_re   <= 1'b1;
      end else if (issue_cpu && cpu_req) begin
        mem_addr  <= cpu_addr;
        mem_re    <= !cpu_we;
        mem_we    <= cpu_we;
        mem_wdata <= cpu_wdata;
        cpu_grant <= 1'b1;
      end
    end
  end

  // capture the fetched bytes two cycles after issue
  always_ff @(posedge clk) begin
    if (rst) begin
      up_byte <= '0;
      lo_byte <= '0;
    end else begin
      if (cap_up) up_byte <= mem_rdata;
      if (cap_lo) lo_byte <= mem_rdata;
    end
  end

  // R3
  half_gap_chk: assert property (@(posedge clk) disable iff (rst)
    issue_up |-> (la - ua) == area_a);

  // R8
  grant_req_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_grant |-> $past(cpu_req));

  // R8
  write_slot_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> cpu_grant && !mem_re);
endmodule

// File: rtl/lcd_scan_shift.sv
module lcd_scan_shift
  import lcd_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              show,
  output logic              dot
);
  logic [BYTE_W-1:0] sh;

  // least significant bit leaves first
  always_ff @(posedge clk) begin
    if (rst)       sh <= '0;
    else if (load) sh <= byte_in;
    else           sh <= sh >> 1;
  end

  assign dot = sh[0] & show;
endmodule

// File: rtl/lcd_dual_scan.sv
module lcd_dual_scan
  import lcd_scan_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int HN_W   = 7,
  parameter int NX_W   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        pitch_m1,
  input  logic [HN_W-1:0]   hn_m1,
  input  logic [NX_W-1:0]   nx_m1,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              disp_on,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic              cpu_grant,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              up_dot,
  output logic              lo_dot,
  output logic              dot_valid,
  output logic              line_latch,
  output logic              frame_mark,
  output logic              ac_flip
);
  localparam int HALVES = 2;

  logic period_end, issue_up, issue_lo, issue_cpu, cap_up, cap_lo, last_byte, show_on;
  logic [HALVES-1:0][BYTE_W-1:0] half_byte;
  logic [HALVES-1:0]             half_dot;

  lcd_scan_timing #(.HN_W(HN_W), .NX_W(NX_W)) u_timing (
    .clk(clk), .rst(rst), .pitch_m1(pitch_m1), .hn_m1(hn_m1), .nx_m1(nx_m1),
    .disp_on(disp_on), .period_end(period_end), .issue_up(issue_up),
    .issue_lo(issue_lo), .issue_cpu(issue_cpu), .cap_up(cap_up), .cap_lo(cap_lo),
    .last_byte(last_byte), .show_on(show_on), .line_latch(line_latch),
    .frame_mark(frame_mark), .ac_flip(ac_flip), .dot_valid(dot_valid)
  );

  lcd_scan_fetch #(.ADDR_W(ADDR_W), .HN_W(HN_W), .NX_W(NX_W)) u_fetch (
    .clk(clk), .rst(rst), .hn_m1(hn_m1), .nx_m1(nx_m1), .start_addr(start_addr),
    .issue_up(issue_up), .issue_lo(issue_lo), .issue_cpu(issue_cpu),
    .cap_up(cap_up), .cap_lo(cap_lo), .last_byte(last_byte),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .cpu_grant(cpu_grant),
    .up_byte(half_byte[0]), .lo_byte(half_byte[1])
  );

  for (genvar g = 0; g < HALVES; g++) begin : g_half
    lcd_scan_shift u_shift (
      .clk(clk), .rst(rst), .load(period_end), .byte_in(half_byte[g]),
      .show(show_on), .dot(half_dot[g])
    );
  end

  assign up_dot = half_dot[0];
  assign lo_dot = half_dot[1];

  // R9
  dark_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(disp_on) |-> (!up_dot && !lo_dot));
endmodule

// File: tb/lcd_dual_scan_tb.sv
module lcd_dual_scan_tb;
  localparam int ADDR_W = 16;
  localparam int HN_W   = 7;
  localparam int NX_W   = 7;
  localparam int RAM_N  = 1024;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2:0]        pitch_m1 = 3'd5;
  logic [HN_W-1:0]   hn_m1 = '0;
  logic [NX_W-1:0]   nx_m1 = '0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic              disp_on = 1'b0;
  logic              cpu_req = 1'b0;
  logic              cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [7:0]        cpu_wdata = '0;
  logic              cpu_grant;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_re, mem_we;
  logic [7:0]        mem_wdata;
  logic [7:0]        mem_rdata = '0;
  logic              up_dot, lo_dot, dot_valid, line_latch, frame_mark, ac_flip;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [7:0] ram [RAM_N];

  always #10 clk = ~clk;

  lcd_dual_scan #(.ADDR_W(ADDR_W), .HN_W(HN_W), .NX_W(NX_W)) u_dut (
    .clk(clk), .rst(rst), .pitch_m1(pitch_m1), .hn_m1(hn_m1), .nx_m1(nx_m1),
    .start_addr(start_addr), .disp_on(disp_on), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_grant(cpu_grant),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .up_dot(up_dot), .lo_dot(lo_dot), .dot_valid(dot_valid),
    .line_latch(line_latch), .frame_mark(frame_mark), .ac_flip(ac_flip)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'(((a * 29) + 7) ^ (a >> 2));
  endfunction

  // synchronous RAM model
  always @(posedge clk) begin
    if (mem_we) ram[int'(mem_addr) % RAM_N] <= mem_wdata;
    if (mem_re) mem_rdata <= ram[int'(mem_addr) % RAM_N];
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic apply_reset(input logic [2:0] pm1, input int hn, input int nx,
                             input int st, input logic on);
    @(negedge clk);
    rst        = 1'b1;
    pitch_m1   = pm1;
    hn_m1      = HN_W'(hn - 1);
    nx_m1      = NX_W'(nx - 1);
    start_addr = ADDR_W'(st);
    disp_on    = on;
    repeat (3) @(negedge clk);
    // R1: outputs idle while reset is held
    chk({up_dot, lo_dot, dot_valid, line_latch, frame_mark, ac_flip,
         mem_re, mem_we, cpu_grant} == '0, "R1 reset", int'(dot_valid), 0);
    rst = 1'b0;
  endtask

  // sweep whole frames, comparing every output every cycle
  task automatic sweep(input logic [2:0] pm1, input int hn, input int nx,
                       input int st, input logic on, input int frames);
    int hp, f, total;
    logic exp_ac;
    hp     = (pm1 < 3'd5) ? 6 : int'(pm1) + 1;
    f      = hn * nx;
    total  = hp * f * frames + 3 * hp;
    exp_ac = 1'b0;
    apply_reset(pm1, hn, nx, st, on);
    for (int c = 0; c < total; c++) begin
      int k, p, m, eu, el;
      logic e_lat;
      k = c / hp;
      p = c % hp;
      if (c == 0)
        chk({up_dot, lo_dot, dot_valid, line_latch, frame_mark, ac_flip,
             mem_re, mem_we, cpu_grant} == '0, "R1 first cycle", int'(dot_valid), 0);
      // R3 fetch phases and addresses
      m = k % f;
      if (p == 1) begin
        chk(mem_re && int'(mem_addr) == ((st + m) % 65536), "R3 upper fetch",
            int'(mem_addr), (st + m) % 65536);
      end else if (p == hp - 3) begin
        chk(mem_re && int'(mem_addr) == ((st + f + m) % 65536), "R3 lower fetch",
            int'(mem_addr), (st + f + m) % 65536);
      end else begin
        // R2 / R8 no bus activity outside the fetch phases without a request
        chk(!mem_re, "R2 R8 idle phase", int'(mem_re), 0);
      end
      chk(!mem_we && !cpu_grant, "R8 no request", int'(mem_we), 0);
      // R4 serial dots, R9 display off
      if (k >= 1) begin
        int j;
        j  = (k - 1) % f;
        eu = on ? int'(pat((st + j) % 65536 % RAM_N)[p]) : 0;
        el = on ? int'(pat((st + f + j) % 65536 % RAM_N)[p]) : 0;
      end else begin
        eu = 0;
        el = 0;
      end
      chk(int'(up_dot) == eu, on ? "R4 upper dot" : "R9 upper dark", int'(up_dot), eu);
      chk(int'(lo_dot) == el, on ? "R4 lower dot" : "R9 lower dark", int'(lo_dot), el);
      chk(dot_valid == (k >= 1), "R4 dot_valid", int'(dot_valid), int'(k >= 1));
      // R5 line latch
      e_lat = (p == 0) && (k >= 2) && (((k - 2) % hn) == hn - 1);
      chk(line_latch == e_lat, "R5 line_latch", int'(line_latch), int'(e_lat));
      // R6 frame marker
      chk(frame_mark == ((k >= 1) && (((k - 1) % f) < hn)), "R6 frame_mark",
          int'(frame_mark), int'((k >= 1) && (((k - 1) % f) < hn)));
      // R7 AC flip
      if ((p == 0) && (k >= 2) && (((k - 2) % f) == f - 1)) exp_ac = ~exp_ac;
      chk(ac_flip == exp_ac, "R7 ac_flip", int'(ac_flip), int'(exp_ac));
      @(negedge clk);
    end
  endtask

  // R8 host write then read through the third slot
  task automatic host_access(input logic [2:0] pm1, input int hn, input int nx, input int st);
    int hp, c, gc;
    bit got;
    hp = int'(pm1) + 1;
    apply_reset(pm1, hn, nx, st, 1'b1);
    c = 0;
    repeat (5) begin @(negedge clk); c++; end
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 16'h0300; cpu_wdata = 8'hA5;
    got = 1'b0; gc = 0;
    for (int i = 0; i < 3 * hp && !got; i++) begin
      @(negedge clk); c++;
      if (cpu_grant) begin got = 1'b1; gc = c; end
    end
    chk(got, "R8 write granted", int'(got), 1);
    chk(gc % hp == hp - 1, "R8 write phase", gc % hp, hp - 1);
    chk(mem_we && !mem_re && mem_addr == 16'h0300 && mem_wdata == 8'hA5,
        "R8 write bus", int'(mem_wdata), 165);
    cpu_req = 1'b0; cpu_we = 1'b0;
    repeat (2) begin @(negedge clk); c++; end
    cpu_req = 1'b1;
    got = 1'b0;
    for (int i = 0; i < 3 * hp && !got; i++) begin
      @(negedge clk); c++;
      if (cpu_grant) begin got = 1'b1; gc = c; end
    end
    chk(got && gc % hp == hp - 1, "R8 read phase", gc % hp, hp - 1);
    chk(mem_re && !mem_we && mem_addr == 16'h0300, "R8 read bus", int'(mem_addr), 768);
    cpu_req = 1'b0;
    @(negedge clk);
    chk(mem_rdata == 8'hA5, "R8 read data", int'(mem_rdata), 165);
    ram[768] = pat(768);
  endtask

  initial begin
    for (int i = 0; i < RAM_N; i++) ram[i] = pat(i);
    sweep(3'd5, 2, 2, 16'h0010, 1'b1, 3);   // pitch 6
    sweep(3'd6, 3, 2, 16'h0040, 1'b1, 3);   // pitch 7
    sweep(3'd7, 4, 3, 16'h03F8, 1'b1, 3);   // pitch 8, RAM wrap
    sweep(3'd2, 2, 3, 16'h0100, 1'b1, 2);   // R2 clamped code
    sweep(3'd7, 2, 2, 16'h0020, 1'b0, 2);   // R9 display off
    sweep(3'd5, 1, 1, 16'h0200, 1'b1, 4);   // one byte per frame
    host_access(3'd6, 3, 2, 16'h0040);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule